// File: doc/BRIEF.md
# Warped Pixel Splat Address Stage

This stage sits at the tail of a per-pixel reprojection pipeline. Each incoming pixel carries two unsigned fixed-point coordinates on the new view plane, `h` (horizontal) and `k` (vertical), and a 16-bit RGB colour. The stage first tests whether both coordinates fall inside the unit interval. A pixel that fails the test is dropped silently. A pixel that passes has its coordinates scaled by the view resolution. The scaled values become a column and a row, and these are combined into a linear framebuffer address. The stage then issues one write request that carries the colour.

Pixels enter in scan order through a valid/ready handshake. Write requests leave through a second valid/ready handshake toward a memory controller. Back-pressure works as follows. While a write request is outstanding, `pix_ready` stays low. A pending request keeps its address and colour unchanged until `wr_ready` accepts it. Writes therefore reach memory in the same order the pixels arrived, which keeps a scan-ordered stream suited to burst grouping.

The upstream source marks the final pixel of a frame with `pix_last`. One cycle after that pixel is accepted, the stage pulses `frame_done` and presents the number of pixels written and dropped in the frame. The counts then remain on their outputs until the next frame's report.

Top module: `splat_addr_stage`

## Requirements
- R1: A pixel accepted on the input handshake whose `pix_h` and `pix_k` are both at most 1.0 (Q1.16 encoding, 1.0 = 0x10000, unsigned so never negative) produces exactly one write request.
- R2: A pixel whose `pix_h` or `pix_k` exceeds 0x10000 produces no write request and leaves `wr_valid` low.
- R3: The column is floor(`pix_h` × RES_X / 65536) and the row is floor(`pix_k` × RES_Y / 65536); fractions are truncated toward zero.
- R4: A scaled value equal to the resolution, which happens only at exactly 1.0, is clamped to the resolution minus 1 (511 for the default 512).
- R5: `wr_addr` = row × RES_X + column. For the default 512 × 512 view, this is the 18-bit value {row[8:0], column[8:0]}.
- R6: `wr_data` equals the `pix_rgb` of the pixel that caused the write.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R8: `pix_ready` is low exactly while a write request is pending (from the cycle after an in-range pixel is accepted until the cycle after `wr_ready` takes it), and high otherwise.
- R9: The write request appears in the cycle after the input handshake.
- R10: In the cycle after the handshake of a pixel with `pix_last` high, `frame_done` pulses for one cycle. At the same time, `frame_written` and `frame_dropped` show that frame's counts, including the last pixel. Both counts hold until the next report, and counting restarts from zero.
- R11: In reset, `wr_valid` and `frame_done` are low, `pix_ready` is high, and both frame counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Stage can take a pixel |
| pix_h | input | 17 | Horizontal view-plane parameter, Q1.16 |
| pix_k | input | 17 | Vertical view-plane parameter, Q1.16 |
| pix_rgb | input | 16 | Pixel colour |
| pix_last | input | 1 | Last pixel of the frame |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory side takes the write |
| wr_addr | output | 18 | Linear framebuffer address |
| wr_data | output | 16 | Colour to write |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_written | output | 19 | Pixels written in the last reported frame |
| frame_dropped | output | 19 | Pixels dropped in the last reported frame |

## Verification
A write request, along with its address and data, is due one clock edge after the input handshake that caused it. The frame report is due one edge after the handshake of the last pixel. `pix_ready` falls on the edge that registers a write and rises on the edge after `wr_ready` takes that write. The reference model steps on the same rising edge as the design and uses the inputs that were stable before that edge. Every output is compared with the model at the following falling edge, so each result is checked in the exact cycle it is due. Stalls on `wr_ready`, including a long directed stall, exercise the hold rule cycle by cycle.

// File: rtl/splat_pkg.sv
package splat_pkg;
  localparam int DEF_FRAC_W  = 16;
  localparam int DEF_RES_X   = 512;
  localparam int DEF_RES_Y   = 512;
  localparam int DEF_COLOR_W = 16;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/splat_range_test.sv
module splat_range_test #(
  parameter int FRAC_W = 16
) (
  input  logic [FRAC_W:0] h,
  input  logic [FRAC_W:0] k,
  output logic            in_view
);
  localparam logic [FRAC_W:0] UNIT = (FRAC_W + 1)'(1) << FRAC_W;

  // both operands unsigned, so only the upper bound needs testing
  always_comb in_view = (h <= UNIT) && (k <= UNIT);
endmodule

// File: rtl/splat_axis_scale.sv
module splat_axis_scale #(
  parameter int FRAC_W = 16,
  parameter int RES    = 512,
  parameter int OUT_W  = 9
) (
  input  logic [FRAC_W:0]  frac_pos,
  output logic [OUT_W-1:0] coord
);
  localparam int RW = $clog2(RES + 1);
  localparam int PW = FRAC_W + 1 + RW;
  localparam int WW = PW - FRAC_W;

  logic [PW-1:0] prod;
  logic [WW-1:0] whole;

  always_comb begin
    prod  = PW'(frac_pos) * PW'(RES);
    whole = prod[PW-1:FRAC_W];
    if (whole >= WW'(RES)) coord = OUT_W'(RES - 1);
    else                   coord = OUT_W'(whole);
  end
endmodule

// File: rtl/splat_addr_gen.sv
module splat_addr_gen #(
  parameter int RES_X  = 512,
  parameter int XW     = 9,
  parameter int YW     = 9,
  parameter int ADDR_W = 18
) (
  input  logic [XW-1:0]     col,
  input  logic [YW-1:0]     row,
  output logic [ADDR_W-1:0] addr
);
  generate
    if (splat_pkg::is_pow2(RES_X)) begin : g_concat
      always_comb addr = ADDR_W'({row, col});
    end else begin : g_mult
      always_comb addr = ADDR_W'(row) * ADDR_W'(RES_X) + ADDR_W'(col);
    end
  endgenerate
endmodule

// File: rtl/splat_frame_count.sv
module splat_frame_count #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             hit,
  input  logic             last,
  output logic             done,
  output logic [CNT_W-1:0] rep_written,
  output logic [CNT_W-1:0] rep_dropped
);
  logic [CNT_W-1:0] n_wr, n_dr, n_wr_nxt, n_dr_nxt;

  always_comb begin
    n_wr_nxt = n_wr + CNT_W'(take && hit);
    n_dr_nxt = n_dr + CNT_W'(take && !hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_wr        <= '0;
      n_dr        <= '0;
      done        <= 1'b0;
      rep_written <= '0;
      rep_dropped <= '0;
    end else begin
      done <= take && last;
      if (take && last) begin
        rep_written <= n_wr_nxt;
        rep_dropped <= n_dr_nxt;
        n_wr        <= '0;
        n_dr        <= '0;
      end else begin
        n_wr <= n_wr_nxt;
        n_dr <= n_dr_nxt;
      end
    end
  end
endmodule

// File: rtl/splat_addr_stage.sv
module splat_addr_stage #(
  parameter int FRAC_W  = splat_pkg::DEF_FRAC_W,
  parameter int RES_X   = splat_pkg::DEF_RES_X,
  parameter int RES_Y   = splat_pkg::DEF_RES_Y,
  parameter int COLOR_W = splat_pkg::DEF_COLOR_W,
  localparam int ADDR_W = $clog2(RES_X * RES_Y),
  localparam int CNT_W  = $clog2(RES_X * RES_Y + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [FRAC_W:0]    pix_h,
  input  logic [FRAC_W:0]    pix_k,
  input  logic [COLOR_W-1:0] pix_rgb,
  input  logic               pix_last,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [COLOR_W-1:0] wr_data,
  output logic               frame_done,
  output logic [CNT_W-1:0]   frame_written,
  output logic [CNT_W-1:0]   frame_dropped
);
  localparam int XW = $clog2(RES_X);
  localparam int YW = $clog2(RES_Y);

  logic              in_view;
  logic              take;
  logic [XW-1:0]     col;
  logic [YW-1:0]     row;
  logic [ADDR_W-1:0] addr_c;

  splat_range_test #(.FRAC_W(FRAC_W)) u_range (
    .h(pix_h), .k(pix_k), .in_view(in_view)
  );

  splat_axis_scale #(.FRAC_W(FRAC_W), .RES(RES_X), .OUT_W(XW)) u_scale_x (
    .frac_pos(pix_h), .coord(col)
  );

  splat_axis_scale #(.FRAC_W(FRAC_W), .RES(RES_Y), .OUT_W(YW)) u_scale_y (
    .frac_pos(pix_k), .coord(row)
  );

  splat_addr_gen #(.RES_X(RES_X), .XW(XW), .YW(YW), .ADDR_W(ADDR_W)) u_addr (
    .col(col), .row(row), .addr(addr_c)
  );

  // one write slot: the input stalls while it is occupied
  assign pix_ready = !wr_valid;
  assign take      = pix_valid && pix_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (take && in_view) begin
        wr_valid <= 1'b1;
        wr_addr  <= addr_c;
        wr_data  <= pix_rgb;
      end
    end
  end

  splat_frame_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .take(take), .hit(in_view), .last(pix_last),
    .done(frame_done), .rep_written(frame_written), .rep_dropped(frame_dropped)
  );
endmodule

// File: rtl/splat_addr_stage_chk.sv
module splat_addr_stage_chk #(
  parameter int FRAC_W  = 16,
  parameter int RES_X   = 512,
  parameter int ADDR_W  = 18,
  parameter int COLOR_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_valid,
  input logic               pix_ready,
  input logic [FRAC_W:0]    pix_h,
  input logic [FRAC_W:0]    pix_k,
  input logic [COLOR_W-1:0] pix_rgb,
  input logic               pix_last,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [COLOR_W-1:0] wr_data,
  input logic               frame_done
);
  localparam logic [FRAC_W:0] UNIT = (FRAC_W + 1)'(1) << FRAC_W;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_h <= UNIT && pix_k <= UNIT)
      |=> (wr_valid && wr_data == $past(pix_rgb)));

  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && (pix_h > UNIT || pix_k > UNIT)) |=> !wr_valid);

  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_h == UNIT && pix_k <= UNIT)
      |=> ((wr_addr % ADDR_W'(RES_X)) == ADDR_W'(RES_X - 1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_last) |=> frame_done);

  p_nodone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pix_ready && pix_last) |=> !frame_done);
endmodule

bind splat_addr_stage splat_addr_stage_chk #(
  .FRAC_W(FRAC_W), .RES_X(RES_X), .ADDR_W(ADDR_W), .COLOR_W(COLOR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_h(pix_h), .pix_k(pix_k), .pix_rgb(pix_rgb), .pix_last(pix_last),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .frame_done(frame_done)
);

// File: tb/splat_addr_stage_tb.sv
module splat_addr_stage_tb;
  localparam int RX = 512;
  localparam int RY = 512;
  localparam int ONE = 65536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [16:0] pix_h = '0;
  logic [16:0] pix_k = '0;
  logic [15:0] pix_rgb = '0;
  logic        pix_last = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [17:0] wr_addr;
  logic [15:0] wr_data;
  logic        frame_done;
  logic [18:0] frame_written, frame_dropped;

  int checks = 0, failures = 0, cycles = 0;
  int ready_mode = 0;   // 0 always, 1 random, 2 held low
  bit finished = 0;

  // behavioural reference state
  bit m_pend = 0, m_done = 0;
  int m_addr = 0, m_data = 0, m_cnt_w = 0, m_cnt_d = 0, m_rep_w = 0, m_rep_d = 0;

  always #5 clk = ~clk;

  splat_addr_stage u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_h(pix_h), .pix_k(pix_k), .pix_rgb(pix_rgb), .pix_last(pix_last),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_done(frame_done),
    .frame_written(frame_written), .frame_dropped(frame_dropped)
  );

  function automatic int scale(input int v, input int res);
    longint p;
    p = (longint'(v) * res) / ONE;
    if (p >= res) p = res - 1;
    return int'(p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model steps on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pend = 0; m_done = 0; m_cnt_w = 0; m_cnt_d = 0; m_rep_w = 0; m_rep_d = 0;
    end else begin
      bit take, ok;
      take = pix_valid && !m_pend;
      if (m_pend && wr_ready) m_pend = 0;
      m_done = 0;
      if (take) begin
        ok = (pix_h <= ONE) && (pix_k <= ONE);
        if (ok) begin
          m_pend = 1;
          m_addr = scale(int'(pix_k), RY) * RX + scale(int'(pix_h), RX);
          m_data = int'(pix_rgb);
          m_cnt_w++;
        end else m_cnt_d++;
        if (pix_last) begin
          m_done = 1; m_rep_w = m_cnt_w; m_rep_d = m_cnt_d; m_cnt_w = 0; m_cnt_d = 0;
        end
      end
    end
  end

  // compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 pix_ready", int'(pix_ready), int'(!m_pend));
      chk("R9/R1/R2 wr_valid", int'(wr_valid), int'(m_pend));
      if (m_pend) begin
        chk("R3 R5 wr_addr", int'(wr_addr), m_addr);
        chk("R6 wr_data", int'(wr_data), m_data);
      end
      chk("R10 frame_done", int'(frame_done), int'(m_done));
      chk("R10 frame_written", int'(frame_written), m_rep_w);
      chk("R10 frame_dropped", int'(frame_dropped), m_rep_d);
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = ($urandom_range(0, 3) != 0);
      default: wr_ready = 1'b0;
    endcase
  end

  task automatic send(input int h, input int k, input int rgb, input bit last);
    bit rd;
    pix_valid = 1'b1; pix_h = 17'(h); pix_k = 17'(k); pix_rgb = 16'(rgb); pix_last = last;
    forever begin
      rd = pix_ready;
      @(negedge clk);
      if (rd) break;
    end
    pix_valid = 1'b0; pix_last = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 wr_valid", int'(wr_valid), 0);
    chk("R11 pix_ready", int'(pix_ready), 1);
    chk("R11 frame_done", int'(frame_done), 0);
    chk("R11 frame_written", int'(frame_written), 0);
    chk("R11 frame_dropped", int'(frame_dropped), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R3 R5: origin and midpoints
    send(0, 0, 'h1234, 0);
    send('h8000, 'h4000, 'hABCD, 0);
    send('hFFFF, 'hFFFF, 'h0F0F, 0);
    // R4: exact 1.0 clamps on each axis
    send(ONE, ONE, 'h7777, 0);
    send(ONE, 0, 'h1111, 0);
    // R2: just above 1.0 and far above, each axis
    send(ONE + 1, 0, 'h2222, 0);
    send(0, 'h1FFFF, 'h3333, 0);
    send('h1FFFF, 'h1FFFF, 'h4444, 1);
    // R7: long stall holds the request
    ready_mode = 2;
    send('h1234, 'h9876, 'h5555, 0);
    repeat (6) @(negedge clk);
    ready_mode = 0;
    send('h0100, 'h0200, 'h6666, 1);
    // back-to-back last pixels, one dropped (R10)
    send(ONE + 5, 0, 0, 1);
    // random frames with random back-pressure
    ready_mode = 1;
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 300; i++)
        send($urandom_range(0, 'h12000), $urandom_range(0, 'h12000),
             $urandom_range(0, 'hFFFF), i == 299);
    end
    ready_mode = 0;
    repeat (5) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule